// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out the loop primitive of a small processor core: one instruction that may step a register down or up by one, or leave it alone, then branch depending on whether the result is zero. A control postbyte selects the step operation, the branch sense, one of eight source registers and the sign of the branch displacement. A following byte supplies the low eight bits of that displacement.

When `start` is high, the unit reads the chosen register through a combinational read port. It computes the stepped value and the zero condition, and adds the sign-extended displacement to the PC value that follows the displacement byte. All results are registered and appear one cycle later with `done`. Accumulators A and B, and any other register marked in `NARROW_MASK`, are handled on the same datapath as 8-bit quantities. The register file, fetch logic and cycle accounting all stay outside the unit.

Top module: `loop_branch_unit`

## Requirements
- R1: Postbyte bits 7:6 = 00 (decrement): one cycle after `start`, `rf_wr_en` is 1 and `rf_wr_data` is the register value minus one.
- R2: Bits 7:6 = 10 (increment): one cycle after `start`, `rf_wr_en` is 1 and `rf_wr_data` is the register value plus one.
- R3: Bits 7:6 = 01 (test): the register is only examined, so `rf_wr_en` stays 0, and the zero condition is taken from the value read.
- R4: Postbyte bit 5 sets the branch sense. With bit 5 = 1, `branch_taken` is 1 when the result is nonzero. With bit 5 = 0, it is 1 when the result is zero.
- R5: Postbyte bits 2:0 pick the register (0 A, 1 B, 2 CCR, 3 temp, 4 D, 5 X, 6 Y, 7 SP). The same code drives `rf_rd_sel` combinationally and appears on `rf_wr_sel` with the result.
- R6: `branch_target` = `pc_next` + the 9-bit two's-complement displacement {postbyte bit 4, offset byte}, taken modulo 2^16.
- R7: For a decrement or increment, the write-back happens whether or not the branch is taken.
- R8: For registers 0 and 1, the step wraps at 8 bits, only bits 7:0 of the read value count for the step and the zero test, and `rf_wr_data[15:8]` is 0.
- R9: Bits 7:6 = 11 sets `illegal_op` to 1 with `rf_wr_en` 0 and `branch_taken` 0.
- R10: After reset, `done`, `rf_wr_en`, `branch_taken`, `illegal_op`, `rf_wr_data` and `branch_target` are all 0.
- R11: `done` is 1 exactly in the cycle after a cycle with `start` high. While `done` is 0, `rf_wr_en`, `branch_taken` and `illegal_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Execute the loop operation this cycle |
| postbyte | input | 8 | Operation, sense, displacement sign, register |
| offset | input | 8 | Low byte of the branch displacement |
| pc_next | input | 16 | PC value after the displacement byte |
| rf_rd_sel | output | 3 | Register file read select |
| rf_rd_data | input | 16 | Register file read data |
| rf_wr_en | output | 1 | Register write-back enable |
| rf_wr_sel | output | 3 | Register write-back select |
| rf_wr_data | output | 16 | Register write-back value |
| done | output | 1 | Results valid |
| branch_taken | output | 1 | Branch condition met |
| branch_target | output | 16 | Computed branch address |
| illegal_op | output | 1 | Reserved operation code seen |

## Verification
The assertions check the following on every cycle:
- the one-cycle relation between `start` and `done`;
- that every output is quiet while no result is valid;
- that an illegal code neither writes nor branches;
- that a step operation always writes back while a test never does;
- that the upper byte of a narrow result is clear.

The arithmetic can only be shown by the bench's sweep, which runs every postbyte against chosen register, displacement and PC values. That arithmetic covers wrap at both widths, the branch sense on each zero outcome, and the sign-extended target.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

  typedef enum logic [1:0] {
    STEP_DOWN = 2'b00,
    STEP_NONE = 2'b01,
    STEP_UP   = 2'b10,
    STEP_RSVD = 2'b11
  } step_op_e;

  localparam int PB_OP_HI   = 7;
  localparam int PB_OP_LO   = 6;
  localparam int PB_SENSE   = 5;
  localparam int PB_SIGN    = 4;
  localparam int PB_SEL_HI  = 2;
  localparam int SEL_BITS   = PB_SEL_HI + 1;

  typedef struct packed {
    step_op_e          op;
    logic              on_nonzero;
    logic              disp_neg;
    logic [SEL_BITS-1:0] sel;
    logic              narrow;
  } lcb_ctrl_t;

endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
#(
  parameter int          NREG        = 8,
  parameter logic [NREG-1:0] NARROW_MASK = 8'b0000_0011
) (
  input  logic [7:0] postbyte,
  output lcb_ctrl_t  ctrl,
  output logic       legal
);
  always_comb begin
    ctrl.op         = step_op_e'(postbyte[PB_OP_HI:PB_OP_LO]);
    ctrl.on_nonzero = postbyte[PB_SENSE];
    ctrl.disp_neg   = postbyte[PB_SIGN];
    ctrl.sel        = postbyte[PB_SEL_HI:0];
    ctrl.narrow     = NARROW_MASK[ctrl.sel];
    legal           = (ctrl.op != STEP_RSVD);
  end
endmodule

// File: rtl/lcb_step.sv
module lcb_step
  import lcb_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  step_op_e        op,
  input  logic            narrow,
  input  logic [DW-1:0]   value_in,
  output logic [DW-1:0]   value_out,
  output logic            is_zero,
  output logic            modifies
);
  function automatic logic [DW-1:0] limit_width(input logic [DW-1:0] v, input logic n);
    logic [DW-1:0] m;
    m = n ? {{(DW-NW){1'b0}}, {NW{1'b1}}} : {DW{1'b1}};
    return v & m;
  endfunction

  function automatic logic [DW-1:0] step_value(input step_op_e o, input logic [DW-1:0] v);
    case (o)
      STEP_DOWN: return v - 1'b1;
      STEP_UP:   return v + 1'b1;
      default:   return v;
    endcase
  endfunction

  logic [DW-1:0] operand;

  always_comb begin
    operand   = limit_width(value_in, narrow);
    value_out = limit_width(step_value(op, operand), narrow);
    is_zero   = (value_out == '0);
    modifies  = (op == STEP_DOWN) || (op == STEP_UP);
  end
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] pc_base,
  input  logic          disp_neg,
  input  logic [OW-1:0] disp_low,
  output logic [AW-1:0] target
);
  function automatic logic [AW-1:0] widen_disp(input logic s, input logic [OW-1:0] d);
    return {{(AW-OW){s}}, d};
  endfunction

  always_comb target = pc_base + widen_disp(disp_neg, disp_low);
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lcb_pkg::*;
#(
  parameter int              DW          = 16,
  parameter int              AW          = 16,
  parameter int              NW          = 8,
  parameter int              OW          = 8,
  parameter logic [7:0]      NARROW_MASK = 8'b0000_0011
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          postbyte,
  input  logic [OW-1:0]       offset,
  input  logic [AW-1:0]       pc_next,
  output logic [SEL_BITS-1:0] rf_rd_sel,
  input  logic [DW-1:0]       rf_rd_data,
  output logic                rf_wr_en,
  output logic [SEL_BITS-1:0] rf_wr_sel,
  output logic [DW-1:0]       rf_wr_data,
  output logic                done,
  output logic                branch_taken,
  output logic [AW-1:0]       branch_target,
  output logic                illegal_op
);
  localparam int NREG = 1 << SEL_BITS;

  lcb_ctrl_t     ctrl;
  logic          legal;
  logic [DW-1:0] stepped;
  logic          res_zero;
  logic          res_writes;
  logic [AW-1:0] tgt;
  logic          cond_met;
  logic          test_q;
  logic          narrow_q;

  lcb_decode #(.NREG(NREG), .NARROW_MASK(NARROW_MASK)) u_dec (
    .postbyte (postbyte),
    .ctrl     (ctrl),
    .legal    (legal)
  );

  lcb_step #(.DW(DW), .NW(NW)) u_step (
    .op        (ctrl.op),
    .narrow    (ctrl.narrow),
    .value_in  (rf_rd_data),
    .value_out (stepped),
    .is_zero   (res_zero),
    .modifies  (res_writes)
  );

  lcb_target #(.AW(AW), .OW(OW)) u_tgt (
    .pc_base  (pc_next),
    .disp_neg (ctrl.disp_neg),
    .disp_low (offset),
    .target   (tgt)
  );

  assign rf_rd_sel = ctrl.sel;
  assign cond_met  = legal && (ctrl.on_nonzero ? !res_zero : res_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done          <= 1'b0;
      rf_wr_en      <= 1'b0;
      rf_wr_sel     <= '0;
      rf_wr_data    <= '0;
      branch_taken  <= 1'b0;
      branch_target <= '0;
      illegal_op    <= 1'b0;
      test_q        <= 1'b0;
      narrow_q      <= 1'b0;
    end else begin
      done         <= start;
      rf_wr_en     <= start && legal && res_writes;
      branch_taken <= start && cond_met;
      illegal_op   <= start && !legal;
      test_q       <= start && (ctrl.op == STEP_NONE);
      if (start) begin
        rf_wr_sel     <= ctrl.sel;
        rf_wr_data    <= stepped;
        branch_target <= tgt;
        narrow_q      <= ctrl.narrow;
      end
    end
  end

  // Result appears one cycle after start (R11)
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!rf_wr_en && !branch_taken && !illegal_op));
  // Reserved code neither writes nor branches (R9)
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!rf_wr_en && !branch_taken));
  // Step operations always write back, taken or not (R7)
  assert_step_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal_op && !test_q) |-> rf_wr_en);
  // Test leaves the register untouched (R3)
  assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |-> !rf_wr_en);
  // Narrow registers carry a clear upper byte (R8)
  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && narrow_q) |-> (rf_wr_data[DW-1:NW] == '0));
endmodule

// File: tb/sim_loop_branch_unit.sv
module sim_loop_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [7:0]  offset = '0;
  logic [15:0] pc_next = '0;
  logic [2:0]  rf_rd_sel;
  logic [15:0] rf_rd_data = '0;
  logic        rf_wr_en;
  logic [2:0]  rf_wr_sel;
  logic [15:0] rf_wr_data;
  logic        done;
  logic        branch_taken;
  logic [15:0] branch_target;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  loop_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .offset(offset), .pc_next(pc_next), .rf_rd_sel(rf_rd_sel),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel),
    .rf_wr_data(rf_wr_data), .done(done), .branch_taken(branch_taken),
    .branch_target(branch_target), .illegal_op(illegal_op)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h pb=%02h val=%04h off=%02h pc=%04h",
               req, act, exp, postbyte, rf_rd_data, offset, pc_next);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vals[8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h00FF, 16'h0100,
                    16'h12FF, 16'hAB00, 16'h8000};
    int offs[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    int pcs[3]  = '{16'h0000, 16'h8001, 16'hFFF0};

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 done", done, 0);
    check("R10 wr_en", rf_wr_en, 0);
    check("R10 taken", branch_taken, 0);
    check("R10 illegal", illegal_op, 0);
    check("R10 wr_data", rf_wr_data, 0);
    check("R10 target", branch_target, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int pb = 0; pb < 256; pb++) begin
      for (int vi = 0; vi < 8; vi++) begin
        for (int oi = 0; oi < 4; oi++) begin
          int op, narrow, v, res, z, exp_taken, exp_wr, exp_ill, disp, exp_tgt, pcv;
          pcv = pcs[(pb + vi + oi) % 3];
          postbyte   = 8'(pb);
          rf_rd_data = 16'(vals[vi]);
          offset     = 8'(offs[oi]);
          pc_next    = 16'(pcv);
          start      = 1'b1;
          #1;
          check("R5 rd_sel", rf_rd_sel, pb & 7);

          op     = (pb >> 6) & 3;
          narrow = ((pb & 7) <= 1) ? 1 : 0;  // R8 registers 0 and 1
          v      = narrow ? (vals[vi] & 'hFF) : vals[vi];
          if (op == 0) res = v - 1;          // R1
          else if (op == 2) res = v + 1;     // R2
          else res = v;                      // R3
          res = narrow ? (res & 'hFF) : (res & 'hFFFF);
          z = (res == 0);
          exp_ill   = (op == 3);
          exp_wr    = (op == 0 || op == 2);
          exp_taken = exp_ill ? 0 : (((pb >> 5) & 1) ? !z : z);
          disp      = ((pb >> 4) & 1) ? offs[oi] - 256 : offs[oi];
          exp_tgt   = (pcv + disp) & 'hFFFF;

          @(negedge clk);
          start = 1'b0;
          check("R11 done", done, 1);
          check("R9 illegal", illegal_op, exp_ill);
          if (op == 1) check("R3 no write", rf_wr_en, 0);
          else if (exp_ill) check("R9 no write", rf_wr_en, 0);
          else check("R7 wr_en", rf_wr_en, exp_wr);
          if (exp_wr) begin
            if (narrow) check("R8 narrow wr_data", rf_wr_data, res);
            else if (op == 0) check("R1 wr_data", rf_wr_data, res);
            else check("R2 wr_data", rf_wr_data, res);
            check("R5 wr_sel", rf_wr_sel, pb & 7);
          end
          if (exp_ill) check("R9 taken", branch_taken, 0);
          else check("R4 taken", branch_taken, exp_taken);
          check("R6 target", branch_target, exp_tgt);

          @(negedge clk);
          check("R11 idle", {done, rf_wr_en, branch_taken, illegal_op}, 0);
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule